// File: doc/BRIEF.md
# DDR2 Extended Mode Register and Output Enable Controller

This block models, on the memory-device side, the extended mode register of a DDR2 part together with the DLL bookkeeping and output-driver gating that the register controls. A decoded command stream arrives on `cmd_i` and `bank_i`. A load-mode command to the extended register captures a 14-bit value. A load-mode command to the base register with its DLL-reset bit set restarts the DLL lock timer, provided the DLL is enabled at that moment. Self-refresh entry turns the DLL off. Self-refresh exit turns it back on and restarts the lock timer.

The block counts the lock interval and raises `dll_locked_o` when the interval has elapsed. Any READ that arrives while the DLL is enabled but not yet locked produces a one-cycle violation pulse. The driver enables for the data pins, the strobe, its complement, the read strobe and the read-strobe complement are formed combinationally. Each one is the read-burst window gated by the register fields and by the x8/x16 strap. The drive-strength select bit is only passed through.

Top module: `ddr2_emr_ctrl`

## Requirements
- R1: While reset is applied, and in the first cycle after it, the captured register reads all zeros. All enables, `dll_locked_o`, `drive_reduced_o` and `rd_early_o` are low.
- R2: A load-mode command (`cmd_i`=1) with `bank_i`=1 stores `mr_val_i` into `emr_q_o`, visible from the next cycle. Load-mode to any other bank leaves `emr_q_o` unchanged. `drive_reduced_o` equals stored bit 1.
- R3: A load-mode command with `bank_i`=0 and `mr_val_i[8]`=1 restarts the lock count, but only while stored bit 0 is 0 and the device is not in self-refresh. If that command is in cycle 0, `dll_locked_o` is low through cycle LOCK_CYCLES-1 and high from cycle LOCK_CYCLES.
- R4: A READ (`cmd_i`=2) in a cycle where the DLL is enabled and `dll_locked_o` is low raises `rd_early_o` for exactly the next cycle. A READ while locked, or while the DLL is disabled, raises nothing.
- R5: Storing bit 0 = 1, or entering self-refresh (`cmd_i`=4), drops `dll_locked_o` in the next cycle. While bit 0 = 1, DLL-reset commands do not start a lock count.
- R6: Self-refresh exit (`cmd_i`=5) with stored bit 0 = 0 restarts the lock count exactly as a DLL reset does.
- R7: With `rd_window_i` low, or stored bit 12 = 1, every output enable is low. Otherwise `dq_oe_o` and `dqs_oe_o` are high.
- R8: `dqs_n_oe_o` equals `dqs_oe_o` while stored bit 10 = 0, and is low while bit 10 = 1.
- R9: `rdqs_oe_o` is high only when `dqs_oe_o` is high, stored bit 11 = 1 and `is_x8_i` = 1. In the x16 strap (`is_x8_i`=0) bit 11 has no effect. A WRITE (`cmd_i`=3) never enables it.
- R10: `rdqs_n_oe_o` is high only when `rdqs_oe_o` is high and stored bit 10 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 idle, 1 load mode, 2 read, 3 write, 4 self-refresh entry, 5 self-refresh exit |
| bank_i | input | 2 | Mode register select: 0 base, 1 extended |
| mr_val_i | input | 14 | Value carried by a load-mode command |
| is_x8_i | input | 1 | Width strap, 1 = x8, 0 = x16 |
| rd_window_i | input | 1 | Read burst window active |
| emr_q_o | output | 14 | Stored extended register |
| drive_reduced_o | output | 1 | Reduced drive strength selected |
| dll_locked_o | output | 1 | DLL lock interval complete |
| rd_early_o | output | 1 | One-cycle pulse: READ before lock |
| dq_oe_o | output | 1 | Data driver enable |
| dqs_oe_o | output | 1 | Strobe driver enable |
| dqs_n_oe_o | output | 1 | Complementary strobe driver enable |
| rdqs_oe_o | output | 1 | Read strobe driver enable |
| rdqs_n_oe_o | output | 1 | Complementary read strobe driver enable |

## Verification
The hardest situation to reach is a READ that falls exactly on the last unlocked cycle, or on the first locked one, after a restart. The restart can come from a base-register DLL reset or from a self-refresh exit. Random traffic almost never lands there, because the interval is 200 cycles and further restarts keep intervening. Directed sequences therefore issue the restart, idle for a computed number of cycles, and place READs on cycles 199 and 200 for both kinds of restart. Long random traffic with rare restarts then covers the remaining interleavings against the cycle model.

// File: rtl/ddr2_emr_ctrl.sv
module ddr2_emr_ctrl #(
  parameter int REG_W       = 14,
  parameter int LOCK_CYCLES = 200,
  parameter int DLL_RST_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [1:0]       bank_i,
  input  logic [REG_W-1:0] mr_val_i,
  input  logic             is_x8_i,
  input  logic             rd_window_i,
  output logic [REG_W-1:0] emr_q_o,
  output logic             drive_reduced_o,
  output logic             dll_locked_o,
  output logic             rd_early_o,
  output logic             dq_oe_o,
  output logic             dqs_oe_o,
  output logic             dqs_n_oe_o,
  output logic             rdqs_oe_o,
  output logic             rdqs_n_oe_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOCK_VAL = CNT_W'(LOCK_CYCLES);
  localparam logic [2:0] C_LOAD = 3'd1, C_READ = 3'd2, C_SRE = 3'd4, C_SRX = 3'd5;
  localparam int B_DLL_OFF = 0, B_DRV = 1, B_NSTRB_OFF = 10, B_RSTRB = 11, B_OUT_OFF = 12;

  logic [REG_W-1:0] emr;
  logic             in_sr, armed;
  logic [CNT_W-1:0] cnt;

  wire ld_ext  = (cmd_i == C_LOAD) && (bank_i == 2'd1);
  wire ld_base = (cmd_i == C_LOAD) && (bank_i == 2'd0);
  wire dll_en  = !emr[B_DLL_OFF] && !in_sr;
  wire dll_off_ev = (ld_ext && mr_val_i[B_DLL_OFF]) || (cmd_i == C_SRE);
  wire dll_rst_ev = (ld_base && mr_val_i[DLL_RST_BIT] && dll_en) ||
                    ((cmd_i == C_SRX) && !emr[B_DLL_OFF]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emr        <= '0;
      in_sr      <= 1'b0;
      armed      <= 1'b0;
      cnt        <= '0;
      rd_early_o <= 1'b0;
    end else begin
      if (ld_ext) emr <= mr_val_i;
      if (cmd_i == C_SRE)      in_sr <= 1'b1;
      else if (cmd_i == C_SRX) in_sr <= 1'b0;
      rd_early_o <= (cmd_i == C_READ) && dll_en && !dll_locked_o;
      if (dll_off_ev) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (dll_rst_ev) begin
        armed <= 1'b1;
        cnt   <= CNT_W'(1);
      end else if (armed && cnt != LOCK_VAL) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign dll_locked_o    = armed && (cnt == LOCK_VAL);
  assign emr_q_o         = emr;
  assign drive_reduced_o = emr[B_DRV];

  wire out_on  = rd_window_i && !emr[B_OUT_OFF];
  wire rstrb   = emr[B_RSTRB] && is_x8_i;

  assign dq_oe_o     = out_on;
  assign dqs_oe_o    = out_on;
  assign dqs_n_oe_o  = out_on && !emr[B_NSTRB_OFF];
  assign rdqs_oe_o   = out_on && rstrb;
  assign rdqs_n_oe_o = out_on && rstrb && !emr[B_NSTRB_OFF];
endmodule

// File: rtl/ddr2_emr_ctrl_chk.sv
module ddr2_emr_ctrl_chk #(
  parameter int REG_W       = 14,
  parameter int LOCK_CYCLES = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_i,
  input logic [1:0]       bank_i,
  input logic [REG_W-1:0] mr_val_i,
  input logic             is_x8_i,
  input logic             rd_window_i,
  input logic [REG_W-1:0] emr_q_o,
  input logic             drive_reduced_o,
  input logic             dll_locked_o,
  input logic             rd_early_o,
  input logic             dq_oe_o,
  input logic             dqs_oe_o,
  input logic             dqs_n_oe_o,
  input logic             rdqs_oe_o,
  input logic             rdqs_n_oe_o
);
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1 && bank_i == 2'd1) |=> (emr_q_o == $past(mr_val_i)));

  a_r2_drive_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1 && bank_i == 2'd1) |=> (drive_reduced_o == $past(mr_val_i[1])));

  a_r4_early_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_early_o |-> $past(cmd_i == 3'd2 && !dll_locked_o));

  a_r5_sre_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd4) |=> !dll_locked_o);

  a_r7_window_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_o || dqs_oe_o || dqs_n_oe_o || rdqs_oe_o || rdqs_n_oe_o) |-> rd_window_i);

  a_r8_nstrb_needs_strb: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_n_oe_o |-> dqs_oe_o);

  a_r9_rstrb_x8_only: assert property (@(posedge clk) disable iff (!rst_n)
    rdqs_oe_o |-> (is_x8_i && dqs_oe_o));

  a_r10_rnstrb_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rdqs_n_oe_o |-> (rdqs_oe_o && dqs_n_oe_o));

  generate
    if (LOCK_CYCLES > 1) begin : g_relock
      a_r3_reset_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && bank_i == 2'd0 && mr_val_i[8] && dll_locked_o) |=> !dll_locked_o);
    end
  endgenerate
endmodule

bind ddr2_emr_ctrl ddr2_emr_ctrl_chk #(.REG_W(REG_W), .LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .mr_val_i(mr_val_i),
  .is_x8_i(is_x8_i), .rd_window_i(rd_window_i), .emr_q_o(emr_q_o),
  .drive_reduced_o(drive_reduced_o), .dll_locked_o(dll_locked_o), .rd_early_o(rd_early_o),
  .dq_oe_o(dq_oe_o), .dqs_oe_o(dqs_oe_o), .dqs_n_oe_o(dqs_n_oe_o),
  .rdqs_oe_o(rdqs_oe_o), .rdqs_n_oe_o(rdqs_n_oe_o));

// File: tb/ddr2_emr_ctrl_tb.sv
`timescale 1ns/1ps
module ddr2_emr_ctrl_tb;
  localparam int LOCK = 200;
  localparam logic [2:0] NOP = 3'd0, LM = 3'd1, RD = 3'd2, WR = 3'd3, SRE = 3'd4, SRX = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 2'd0;
  logic [13:0] val = '0;
  logic x8 = 1'b1, win = 1'b0;
  logic [13:0] emr_q;
  logic drv, locked, early, dq, dqs, dqsn, rdqs, rdqsn;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr2_emr_ctrl #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .mr_val_i(val),
    .is_x8_i(x8), .rd_window_i(win), .emr_q_o(emr_q), .drive_reduced_o(drv),
    .dll_locked_o(locked), .rd_early_o(early), .dq_oe_o(dq), .dqs_oe_o(dqs),
    .dqs_n_oe_o(dqsn), .rdqs_oe_o(rdqs), .rdqs_n_oe_o(rdqsn));

  // behavioural reference
  logic [13:0] m_emr;
  bit m_sr, m_run, m_early;
  int m_age;
  function automatic bit m_locked();
    return m_run && m_age >= LOCK;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_emr <= '0; m_sr <= 0; m_run <= 0; m_age <= 0; m_early <= 0;
    end else begin
      bit enabled;
      enabled = !m_emr[0] && !m_sr;
      m_early <= (cmd == RD) && enabled && !m_locked();
      if (m_run && m_age < LOCK) m_age <= m_age + 1;
      case (cmd)
        LM: begin
          if (bank == 2'd1) begin
            m_emr <= val;
            if (val[0]) begin m_run <= 0; m_age <= 0; end
          end else if (bank == 2'd0 && val[8] && enabled) begin
            m_run <= 1; m_age <= 1;
          end
        end
        SRE: begin m_sr <= 1; m_run <= 0; m_age <= 0; end
        SRX: begin
          m_sr <= 0;
          if (!m_emr[0]) begin m_run <= 1; m_age <= 1; end
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp(input string tag, input logic a, input bit e, input bit in_rst);
    chk(a === e, in_rst ? "R1" : tag, int'(a), int'(e));
  endtask

  always @(negedge clk) begin
    bit on, rs, r;
    r  = !rst_n;
    on = win && !m_emr[12];
    rs = m_emr[11] && x8;
    tests++;
    if (emr_q !== m_emr) begin
      fails++;
      $display("FAIL %s: emr actual %h expected %h", r ? "R1" : "R2", emr_q, m_emr);
    end
    cmp("R2",  drv,    m_emr[1], r);
    cmp("R3",  locked, m_locked(), r);
    cmp("R4",  early,  m_early, r);
    cmp("R7",  dq,     on, r);
    cmp("R7",  dqs,    on, r);
    cmp("R8",  dqsn,   on && !m_emr[10], r);
    cmp("R9",  rdqs,   on && rs, r);
    cmp("R10", rdqsn,  on && rs && !m_emr[10], r);
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [13:0] v);
    cmd = c; bank = b; val = v;
    @(posedge clk); #1;
    cmd = NOP;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(emr_q == 0 && !locked && !dq && !early, "R1", int'(emr_q), 0);
    rst_n = 1'b1;
    idle(1);
    chk(!locked && !dq && !dqs && !rdqs, "R1", int'(locked), 0);

    // R4: read before any DLL reset, DLL enabled by default
    issue(RD, 0, 0);
    chk(early == 1'b1, "R4", int'(early), 1);
    idle(1);
    chk(early == 1'b0, "R4", int'(early), 0);

    // R2: capture and bank filtering
    issue(LM, 1, 14'h0002);
    chk(emr_q == 14'h0002 && drv, "R2", int'(emr_q), 2);
    issue(LM, 2, 14'h1FFF);
    chk(emr_q == 14'h0002, "R2", int'(emr_q), 2);
    issue(LM, 3, 14'h0001);
    chk(emr_q == 14'h0002, "R2", int'(emr_q), 2);

    // R7..R10: field / strap / window sweep
    for (int f = 0; f < 8; f++) begin
      for (int s = 0; s < 2; s++) begin
        logic [13:0] v;
        v = 14'(f) << 10;
        issue(LM, 1, v);
        x8 = s[0];
        win = 1'b0; idle(1);
        chk(!dq && !rdqs, "R7", int'(dq), 0);
        win = 1'b1; idle(1);
        chk(rdqs == (f[1] && s[0] && !f[2]), "R9", int'(rdqs), int'(f[1] && s[0] && !f[2]));
        chk(rdqsn == (f[1] && s[0] && !f[2] && !f[0]), "R10", int'(rdqsn), 0);
        issue(WR, 0, 0);
        win = 1'b0; idle(1);
        chk(!rdqs, "R9", int'(rdqs), 0);
      end
    end
    issue(LM, 1, 14'h0000);
    x8 = 1'b1;

    // R3 boundary: DLL reset, read on cycle LOCK-1 and LOCK
    issue(LM, 0, 14'h0100);
    idle(LOCK - 2);
    chk(!locked, "R3", int'(locked), 0);
    issue(RD, 0, 0);
    chk(early && locked, "R3", int'(locked), 1);
    issue(RD, 0, 0);
    chk(!early, "R4", int'(early), 0);

    // R5: self-refresh drops lock, reads there are not flagged
    issue(SRE, 0, 0);
    chk(!locked, "R5", int'(locked), 0);
    issue(RD, 0, 0);
    chk(!early, "R5", int'(early), 0);

    // R6: exit restarts the count
    issue(SRX, 0, 0);
    idle(LOCK - 2);
    issue(RD, 0, 0);
    chk(early, "R6", int'(early), 1);
    issue(RD, 0, 0);
    chk(!early && locked, "R6", int'(locked), 1);

    // R5: disabling via bit 0; DLL reset ignored
    issue(LM, 1, 14'h0001);
    chk(!locked, "R5", int'(locked), 0);
    issue(LM, 0, 14'h0100);
    idle(LOCK + 5);
    chk(!locked, "R5", int'(locked), 0);
    issue(RD, 0, 0);
    chk(!early, "R5", int'(early), 0);
    issue(LM, 1, 14'h0000);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [13:0] v;
      r = $urandom_range(0, 99);
      v = 14'($urandom());
      if ($urandom_range(0, 7) != 0) v[0] = 1'b0;
      win = 1'($urandom());
      if ($urandom_range(0, 15) == 0) x8 = ~x8;
      if (r < 2)       issue(LM, 2'($urandom()), v);
      else if (r < 3)  issue(LM, 0, 14'h0100);
      else if (r < 4)  issue(SRE, 0, 0);
      else if (r < 6)  issue(SRX, 0, 0);
      else if (r < 30) issue(RD, 0, 0);
      else if (r < 40) issue(WR, 0, 0);
      else             idle(1);
    end

    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule